// File: doc/BRIEF.md
# Subgroup Vote, Ballot and Lane-Mask Unit

This unit computes the cross-lane results that a SIMD group needs when its lanes must agree on something or exchange a value. Each operation presents a packed vector holding one data word per lane, a one-bit predicate per lane, a mask of the lanes that are currently active, the group's nominal size, a lane selector for a directed read and an invocation index. On a start strobe the unit captures six reductions: whether any or all active predicates are set, whether every active lane holds the same word, the ballot of predicates, the word of the lowest-numbered active lane, and the word of the selected lane.

In the same operation it builds five positional lane masks for the invocation index: the lane itself, the lanes below it, the lanes up to and including it, and the lanes at or above it (or strictly above it) up to the group size. The reductions look only at active lanes. The positional masks ignore the active set and depend only on the index and the group size.

All results are registered. They appear on the cycle after the strobe, with a one-cycle done pulse, and they hold until the next strobe.

Top module: `subgroup_lane_unit`

## Requirements
- R1: Bit i of `ballot_o` is set exactly when lane i is active and its predicate is set. A ballot whose predicates are all set equals the active mask.
- R2: `any_o` is 1 when at least one active lane has its predicate set, and 0 otherwise, including when no lane is active.
- R3: `all_o` is 1 when every active lane has its predicate set. With no active lane it is 1.
- R4: `equal_o` is 1 when all active lanes carry the same data word, and inactive lanes have no effect on it. With no active lane it is 1.
- R5: `first_o` is the data word of the lowest-numbered active lane (lane i occupies bits i*DW upward in `lane_val`). With no active lane it is 0.
- R6: `pick_o` is the data word of the lane named by `lane_sel`, whether or not that lane is active.
- R7: `self_mask_o` has only bit `inv_idx` set. `below_mask_o` has bits 0 to `inv_idx`-1 set.
- R8: `upto_mask_o` has bits 0 to `inv_idx` set. This includes the case `inv_idx` = LANES-1, where the mask is all ones.
- R9: `from_mask_o` has bits `inv_idx` to `group_size`-1 set. `above_mask_o` is the same mask with bit `inv_idx` cleared. Both are 0 when `inv_idx` >= `group_size`, and a size of LANES is handled without overflow.
- R10: The results of a strobe appear on the next cycle with `done` high for that one cycle. Without a strobe, `done` is low and all results keep their previous values.
- R11: After synchronous reset, `done` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for one operation |
| lane_val | input | LANES*DW | Per-lane data words, lane 0 in the low bits |
| lane_pred | input | LANES | Per-lane predicate |
| active | input | LANES | Active-lane mask |
| group_size | input | $clog2(LANES+1) | Nominal group size, 0 to LANES |
| lane_sel | input | $clog2(LANES) | Lane to read for `pick_o` |
| inv_idx | input | $clog2(LANES) | Invocation index for positional masks |
| done | output | 1 | Result-valid pulse |
| any_o | output | 1 | Any-vote result |
| all_o | output | 1 | All-vote result |
| equal_o | output | 1 | Uniform-value result |
| ballot_o | output | LANES | Ballot mask |
| first_o | output | DW | Word of lowest active lane |
| pick_o | output | DW | Word of selected lane |
| self_mask_o | output | LANES | Bit at the invocation index |
| below_mask_o | output | LANES | Lanes strictly below the index |
| upto_mask_o | output | LANES | Lanes up to and including the index |
| from_mask_o | output | LANES | Lanes from the index up to the size |
| above_mask_o | output | LANES | Lanes above the index up to the size |

## Verification
The vote/value reductions and the positional mask generation are captured by the same strobe. A fault in either path therefore shows up in the same result cycle as correct data from the other path. The bench drives a sweep over every active-mask pattern of an eight-lane group. Each strobe in that sweep also carries an invocation index and a group size that change with the pattern, so on every step the reduction outputs and all five masks are compared together against independently computed values. A separate exhaustive sweep over every index and size pair covers the mask boundaries, including a size of zero and the full size.

// File: rtl/slg_pkg.sv
package slg_pkg;

  // Positional mask kinds; the order selects the generate slot in the top.
  typedef enum logic [2:0] {
    MK_SELF  = 3'd0,
    MK_BELOW = 3'd1,
    MK_UPTO  = 3'd2,
    MK_FROM  = 3'd3,
    MK_ABOVE = 3'd4
  } mask_kind_e;

  localparam int NUM_MASKS = 5;

  // One bit of a positional mask; evaluated per lane so no shift can overflow.
  function automatic logic mask_bit(mask_kind_e kind, int unsigned pos,
                                    int unsigned inv, int unsigned size);
    case (kind)
      MK_SELF:  return pos == inv;
      MK_BELOW: return pos < inv;
      MK_UPTO:  return pos <= inv;
      MK_FROM:  return (pos >= inv) && (pos < size);
      MK_ABOVE: return (pos > inv) && (pos < size);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/slg_vote_reduce.sv
module slg_vote_reduce #(
  parameter int LANES = 64
) (
  input  logic [LANES-1:0] lane_pred,
  input  logic [LANES-1:0] active,
  output logic             any_v,
  output logic             all_v,
  output logic [LANES-1:0] ballot_v
);

  assign ballot_v = lane_pred & active;
  assign any_v    = |ballot_v;
  // Inactive lanes count as agreeing, so an empty group votes true.
  assign all_v    = &(lane_pred | ~active);

endmodule

// File: rtl/slg_value_reduce.sv
module slg_value_reduce #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] lane_val,
  input  logic [LANES-1:0]    active,
  input  logic [LW-1:0]       lane_sel,
  output logic                equal_v,
  output logic [DW-1:0]       first_v,
  output logic [DW-1:0]       pick_v
);

  logic [LW-1:0]    first_idx;
  logic             found;
  logic [DW-1:0]    ref_word;
  logic [LANES-1:0] agree;

  // Lowest active lane: scan downward so the last hit is the lowest.
  always_comb begin
    first_idx = '0;
    found     = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (active[i]) begin
        first_idx = LW'(i);
        found     = 1'b1;
      end
    end
  end

  assign ref_word = lane_val[first_idx*DW +: DW];
  assign first_v  = found ? ref_word : '0;
  assign pick_v   = lane_val[lane_sel*DW +: DW];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign agree[g] = ~active[g] | (lane_val[g*DW +: DW] == ref_word);
  end

  assign equal_v = &agree;

endmodule

// File: rtl/slg_mask_gen.sv
module slg_mask_gen
  import slg_pkg::*;
#(
  parameter mask_kind_e KIND  = MK_SELF,
  parameter int         LANES = 64,
  parameter int         LW    = $clog2(LANES),
  parameter int         IW    = $clog2(LANES + 1)
) (
  input  logic [LW-1:0]    inv,
  input  logic [IW-1:0]    size,
  output logic [LANES-1:0] mask
);

  for (genvar p = 0; p < LANES; p++) begin : g_bit
    assign mask[p] = mask_bit(KIND, p, 32'(inv), 32'(size));
  end

endmodule

// File: rtl/subgroup_lane_unit.sv
module subgroup_lane_unit
  import slg_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES),
  localparam int IW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LANES*DW-1:0] lane_val,
  input  logic [LANES-1:0]    lane_pred,
  input  logic [LANES-1:0]    active,
  input  logic [IW-1:0]       group_size,
  input  logic [LW-1:0]       lane_sel,
  input  logic [LW-1:0]       inv_idx,
  output logic                done,
  output logic                any_o,
  output logic                all_o,
  output logic                equal_o,
  output logic [LANES-1:0]    ballot_o,
  output logic [DW-1:0]       first_o,
  output logic [DW-1:0]       pick_o,
  output logic [LANES-1:0]    self_mask_o,
  output logic [LANES-1:0]    below_mask_o,
  output logic [LANES-1:0]    upto_mask_o,
  output logic [LANES-1:0]    from_mask_o,
  output logic [LANES-1:0]    above_mask_o
);

  logic             any_c, all_c, equal_c;
  logic [LANES-1:0] ballot_c;
  logic [DW-1:0]    first_c, pick_c;
  logic [LANES-1:0] mask_c [NUM_MASKS];

  slg_vote_reduce #(.LANES(LANES)) u_vote (
    .lane_pred (lane_pred),
    .active    (active),
    .any_v     (any_c),
    .all_v     (all_c),
    .ballot_v  (ballot_c)
  );

  slg_value_reduce #(.LANES(LANES), .DW(DW), .LW(LW)) u_value (
    .lane_val (lane_val),
    .active   (active),
    .lane_sel (lane_sel),
    .equal_v  (equal_c),
    .first_v  (first_c),
    .pick_v   (pick_c)
  );

  for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
    slg_mask_gen #(
      .KIND  (mask_kind_e'(k)),
      .LANES (LANES),
      .LW    (LW),
      .IW    (IW)
    ) u_mask (
      .inv  (inv_idx),
      .size (group_size),
      .mask (mask_c[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      any_o        <= 1'b0;
      all_o        <= 1'b0;
      equal_o      <= 1'b0;
      ballot_o     <= '0;
      first_o      <= '0;
      pick_o       <= '0;
      self_mask_o  <= '0;
      below_mask_o <= '0;
      upto_mask_o  <= '0;
      from_mask_o  <= '0;
      above_mask_o <= '0;
    end else begin
      done <= start;
      if (start) begin
        any_o        <= any_c;
        all_o        <= all_c;
        equal_o      <= equal_c;
        ballot_o     <= ballot_c;
        first_o      <= first_c;
        pick_o       <= pick_c;
        self_mask_o  <= mask_c[MK_SELF];
        below_mask_o <= mask_c[MK_BELOW];
        upto_mask_o  <= mask_c[MK_UPTO];
        from_mask_o  <= mask_c[MK_FROM];
        above_mask_o <= mask_c[MK_ABOVE];
      end
    end
  end

  // Ballot never names a lane that was inactive at capture.
  assert_ballot_in_active_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> ((ballot_o & ~$past(active)) == '0));

  // Any-vote and ballot come from separate registers and must agree.
  assert_any_matches_ballot_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (any_o == (ballot_o != '0)));

  // A true all-vote means every captured active lane is in the ballot.
  assert_all_covers_active_R3: assert property (@(posedge clk) disable iff (rst)
    (done && all_o) |-> (ballot_o == $past(active)));

  // The self mask is a single bit inside the up-to mask.
  assert_self_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(self_mask_o) == 1));

  assert_upto_split_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (upto_mask_o == (below_mask_o | self_mask_o)));

  assert_above_excludes_self_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ((above_mask_o & self_mask_o) == '0 && (above_mask_o & ~from_mask_o) == '0));

  assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_hold_without_start_R10: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && $stable(ballot_o) && $stable(first_o) && $stable(from_mask_o)));

endmodule

// File: tb/subgroup_lane_unit_test.sv
module subgroup_lane_unit_test;

  localparam int LANES = 8;
  localparam int DW    = 8;
  localparam int LW    = $clog2(LANES);
  localparam int IW    = $clog2(LANES + 1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic [LANES*DW-1:0] lane_val = '0;
  logic [LANES-1:0]    lane_pred = '0;
  logic [LANES-1:0]    active = '0;
  logic [IW-1:0]       group_size = '0;
  logic [LW-1:0]       lane_sel = '0;
  logic [LW-1:0]       inv_idx = '0;
  logic                done, any_o, all_o, equal_o;
  logic [LANES-1:0]    ballot_o, self_mask_o, below_mask_o, upto_mask_o;
  logic [LANES-1:0]    from_mask_o, above_mask_o;
  logic [DW-1:0]       first_o, pick_o;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #4 clk = ~clk;

  subgroup_lane_unit #(.LANES(LANES), .DW(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .lane_val(lane_val),
    .lane_pred(lane_pred), .active(active), .group_size(group_size),
    .lane_sel(lane_sel), .inv_idx(inv_idx), .done(done),
    .any_o(any_o), .all_o(all_o), .equal_o(equal_o), .ballot_o(ballot_o),
    .first_o(first_o), .pick_o(pick_o), .self_mask_o(self_mask_o),
    .below_mask_o(below_mask_o), .upto_mask_o(upto_mask_o),
    .from_mask_o(from_mask_o), .above_mask_o(above_mask_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(int i);
    return lane_val[i*DW +: DW];
  endfunction

  // Expected values for the masks, computed from the index and size.
  task automatic check_masks(int inv, int sz);
    logic [LANES-1:0] e_self, e_below, e_upto, e_from, e_above;
    e_self = '0; e_below = '0; e_upto = '0; e_from = '0; e_above = '0;
    for (int p = 0; p < LANES; p++) begin
      e_self[p]  = (p == inv);
      e_below[p] = (p < inv);
      e_upto[p]  = (p <= inv);
      e_from[p]  = (p >= inv) && (p < sz);
      e_above[p] = (p > inv) && (p < sz);
    end
    chk("R7 self", 64'(self_mask_o), 64'(e_self));
    chk("R7 below", 64'(below_mask_o), 64'(e_below));
    chk("R8 upto", 64'(upto_mask_o), 64'(e_upto));
    chk("R9 from", 64'(from_mask_o), 64'(e_from));
    chk("R9 above", 64'(above_mask_o), 64'(e_above));
  endtask

  task automatic check_votes();
    logic e_any, e_all, e_eq, seen;
    logic [LANES-1:0] e_ballot;
    logic [DW-1:0] e_first;
    e_any = 0; e_all = 1; e_eq = 1; seen = 0; e_first = '0; e_ballot = '0;
    for (int i = 0; i < LANES; i++) begin
      if (active[i]) begin
        e_ballot[i] = lane_pred[i];
        if (lane_pred[i]) e_any = 1; else e_all = 0;
        if (!seen) begin e_first = word(i); seen = 1; end
        else if (word(i) != e_first) e_eq = 0;
      end
    end
    chk("R1 ballot", 64'(ballot_o), 64'(e_ballot));
    chk("R2 any", 64'(any_o), 64'(e_any));
    chk("R3 all", 64'(all_o), 64'(e_all));
    chk("R4 equal", 64'(equal_o), 64'(e_eq));
    chk("R5 first", 64'(first_o), 64'(e_first));
    chk("R6 pick", 64'(pick_o), 64'(word(int'(lane_sel))));
  endtask

  // Strobe at a falling edge; results are read at the following falling edge.
  task automatic strobe();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done", 64'(done), 64'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 ballot", 64'(ballot_o), 64'd0);
    chk("R11 first", 64'(first_o), 64'd0);
    chk("R11 masks", 64'(self_mask_o | upto_mask_o | from_mask_o), 64'd0);
    chk("R11 votes", 64'({any_o, all_o, equal_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle done", 64'(done), 64'd0);

    // Votes and masks in the same strobe, over every active pattern.
    for (int a = 0; a < 256; a++) begin
      active    = LANES'(a);
      lane_pred = LANES'((a * 37 + 11) ^ (a >> 2));
      for (int i = 0; i < LANES; i++) lane_val[i*DW +: DW] = 8'h3C;
      if (a[0]) lane_val[((a >> 1) % LANES)*DW +: DW] = 8'hC3;
      if (a[1]) lane_val[((a >> 3) % LANES)*DW +: DW] = 8'h3C + 8'(a);
      lane_sel   = LW'(a + 3);
      inv_idx    = LW'(a);
      group_size = IW'((a >> 3) % (LANES + 1));
      strobe();
      check_votes();
      check_masks(a % LANES, (a >> 3) % (LANES + 1));
    end

    // R1: all-set predicates give the active mask.
    active = 8'hA5; lane_pred = '1;
    strobe();
    chk("R1 const-true ballot", 64'(ballot_o), 64'h A5);

    // Exhaustive mask sweep over index and size.
    for (int inv = 0; inv < LANES; inv++) begin
      for (int sz = 0; sz <= LANES; sz++) begin
        inv_idx = LW'(inv); group_size = IW'(sz);
        strobe();
        check_masks(inv, sz);
      end
    end

    // R10: no strobe -> done low, results held while inputs change.
    begin
      logic [LANES-1:0] held_ballot, held_from;
      logic [DW-1:0] held_first;
      held_ballot = ballot_o; held_from = from_mask_o; held_first = first_o;
      active = ~active; lane_pred = 8'h0F; inv_idx = 3'd1; group_size = 4'd2;
      lane_val = '1;
      @(negedge clk);
      @(negedge clk);
      chk("R10 hold done", 64'(done), 64'd0);
      chk("R10 hold ballot", 64'(ballot_o), 64'(held_ballot));
      chk("R10 hold first", 64'(first_o), 64'(held_first));
      chk("R10 hold mask", 64'(from_mask_o), 64'(held_from));
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule